// File: doc/BRIEF.md
# Indexed Register Window Bridge

This block gives a narrow I/O space access to a wider internal register space through two 32-bit ports. The software first writes an offset into the pointer port, along with a small field that selects the destination. It then reads or writes the data port, and the bridge forwards that access to the internal register bus at the stored offset. A second destination, a translation-table store, can take writes through the same path. Reads aimed at the table come back as zeros.

Access size is taken from the byte enables: all four lanes enabled is a full dword access, and any other pattern counts as a narrow (8- or 16-bit) access. Narrow writes are completed but have no effect, so a bad driver cannot trigger a partial write on the register bus. Narrow reads complete normally and return only the enabled byte lanes.

Every accepted access takes a fixed two-cycle exchange. The downstream request is driven in the cycle after the I/O strobe is sampled, and the acknowledge and read data follow one cycle after that.

Top module: `idx_window_bridge`

## Requirements
- R1: After reset the pointer register holds 00000000h, `io_ack` is low, and neither `reg_req` nor `tbl_wr` is asserted.
- R2: A write to the pointer port (`io_addr[2]`=0) with `io_be`=4'b1111 loads the whole 32-bit pointer from `io_wdata`. Any read of the pointer port returns its contents.
- R3: A pointer-port write with any byte-enable pattern other than 4'b1111 is acknowledged and leaves the pointer unchanged.
- R4: Pointer bits [OFS_W+1:2] give the dword offset driven on `reg_addr` and `tbl_addr`. Pointer bits [1:0] give the destination: 00 is the register space, 01 is the translation table, and 10 and 11 are reserved.
- R5: A full write to the data port (`io_addr[2]`=1) with destination 00 drives `reg_req`=1 and `reg_wr`=1 for one cycle, with `io_wdata` on `reg_wdata`.
- R6: A full data-port write with destination 01 drives `tbl_wr` for one cycle with the write data and offset. `reg_req` stays low, and `reg_req` and `tbl_wr` are never high together.
- R7: A full data-port write with destination 10 or 11 is acknowledged and causes no bus activity.
- R8: Any data-port read issues a register-bus read (`reg_req`=1, `reg_wr`=0) at the pointer offset, whatever the destination. For destinations 00, 10 and 11 it returns `reg_rdata`.
- R9: A data-port read with destination 01 returns all zeros.
- R10: Every read returns zero in the byte lanes whose enable is low. Narrow data-port reads return the enabled lanes of the selected data.
- R11: A data-port write with any byte-enable pattern other than 4'b1111 is acknowledged and drives neither `reg_req` nor `tbl_wr`.
- R12: `io_ack` rises exactly two clock edges after an accepted `io_req`, and any downstream request is driven in the cycle between. A strobe that arrives while an access is in flight is ignored. An initiator waits for `io_ack` before issuing the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_req | input | 1 | Access strobe, one cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | Port offset; bit 2 selects the data port |
| io_be | input | DATA_W/8 | Byte-lane enables |
| io_wdata | input | DATA_W | Write data |
| io_ack | output | 1 | Access complete |
| io_rdata | output | DATA_W | Read data, valid with `io_ack` |
| reg_req | output | 1 | Register-bus request |
| reg_wr | output | 1 | Register-bus write qualifier |
| reg_addr | output | OFS_W | Register-bus dword offset |
| reg_wdata | output | DATA_W | Register-bus write data |
| reg_rdata | input | DATA_W | Register-bus read data, same cycle as `reg_req` |
| tbl_wr | output | 1 | Translation-table write strobe |
| tbl_addr | output | OFS_W | Translation-table dword offset |
| tbl_wdata | output | DATA_W | Translation-table write data |

## Verification
The bench builds the bridge with its default parameters: 32-bit data, a 3-bit port offset and a 16-bit dword offset. At 16 bits, random pointer values reach the top offset bits, while the bench's 16-entry register model aliases on the low four bits. That aliasing lets random writes and later reads hit the same locations often. Random pointer loads spread over all four destination codes, and random byte-enable patterns cover every narrow-versus-full case on both ports.

// File: rtl/idx_window_pkg.sv
// Package: shared types and helpers for the indexed register window bridge.
// Assumes a byte-lane granular data path whose width is a multiple of 8.
package idx_window_pkg;

    typedef enum logic [1:0] {
        DST_REG  = 2'b00,
        DST_TBL  = 2'b01,
        DST_RSV2 = 2'b10,
        DST_RSV3 = 2'b11
    } dst_e;

    // What one accepted access does, decided in the accept cycle.
    typedef struct packed {
        logic ptr_load;   // update the pointer register
        logic bus_req;    // issue a register-bus request
        logic bus_wr;     // register-bus request is a write
        logic tbl_wr;     // issue a table write
        logic rd_ptr;     // read data comes from the pointer
        logic rd_zero;    // read data is forced to zero
    } action_t;

endpackage

// File: rtl/idx_window_decode.sv
// Module: idx_window_decode
// Turns a single I/O access (direction, port, size) plus the current
// destination field into an action. Purely combinational; assumes the caller
// qualifies the result with its own accept strobe.
module idx_window_decode
    import idx_window_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  logic            is_wr,
    input  logic            is_data_port,
    input  logic [BE_W-1:0] be,
    input  dst_e            dst,
    output action_t         act
);

    logic full_access;

    // Full-width means every byte lane is enabled.
    always_comb full_access = &be;

    // Map access kind and destination to the bus actions.
    always_comb begin
        act = '0;
        if (!is_data_port) begin
            act.ptr_load = is_wr && full_access;
            act.rd_ptr   = !is_wr;
        end else if (!is_wr) begin
            act.bus_req = 1'b1;
            act.rd_zero = (dst == DST_TBL);
        end else if (full_access) begin
            unique case (dst)
                DST_REG: begin
                    act.bus_req = 1'b1;
                    act.bus_wr  = 1'b1;
                end
                DST_TBL:  act.tbl_wr = 1'b1;
                default:  act = '0;
            endcase
        end
    end

endmodule

// File: rtl/idx_window_ptr.sv
// Module: idx_window_ptr
// Holds the 32-bit pointer register (offset plus destination field).
// Assumes the load strobe is already qualified by access size.
module idx_window_ptr #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ptr_q
);

    // Reset to zero, otherwise take the full write value on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (load) ptr_q <= wdata;
    end

endmodule

// File: rtl/idx_window_stage.sv
// Module: idx_window_stage
// Two-cycle access engine. Registers the downstream request in the cycle
// after accept, then captures the response and raises the acknowledge.
// Assumes downstream read data is valid in the same cycle as the request.
module idx_window_stage
    import idx_window_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  action_t           act,
    input  logic [BE_W-1:0]   be,
    input  logic [OFS_W-1:0]  offset,
    input  logic [DATA_W-1:0] ptr_val,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              busy,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [OFS_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              tbl_wr,
    output logic [OFS_W-1:0]  tbl_addr,
    output logic [DATA_W-1:0] tbl_wdata,
    output logic              io_ack,
    output logic [DATA_W-1:0] io_rdata
);

    logic              s1_valid;
    logic              s1_rd_ptr;
    logic              s1_rd_zero;
    logic [BE_W-1:0]   s1_be;
    logic [DATA_W-1:0] s1_ptr;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] rd_src;

    assign busy = s1_valid;

    // Widen the stage-one byte enables into a bit mask.
    generate
        for (genvar g = 0; g < BE_W; g++) begin : g_lane
            assign lane_mask[g*8 +: 8] = {8{s1_be[g]}};
        end
    endgenerate

    // Choose the returned word before lane masking.
    always_comb begin
        if (s1_rd_ptr)       rd_src = s1_ptr;
        else if (s1_rd_zero) rd_src = '0;
        else                 rd_src = reg_rdata;
    end

    // Stage one: drive downstream strobes for one cycle after accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_rd_ptr  <= 1'b0;
            s1_rd_zero <= 1'b0;
            s1_be      <= '0;
            s1_ptr     <= '0;
            reg_req    <= 1'b0;
            reg_wr     <= 1'b0;
            reg_addr   <= '0;
            reg_wdata  <= '0;
            tbl_wr     <= 1'b0;
            tbl_addr   <= '0;
            tbl_wdata  <= '0;
        end else begin
            s1_valid   <= accept;
            s1_rd_ptr  <= accept && act.rd_ptr;
            s1_rd_zero <= accept && act.rd_zero;
            reg_req    <= accept && act.bus_req;
            reg_wr     <= accept && act.bus_req && act.bus_wr;
            tbl_wr     <= accept && act.tbl_wr;
            if (accept) begin
                s1_be     <= be;
                s1_ptr    <= ptr_val;
                reg_addr  <= offset;
                reg_wdata <= wdata;
                tbl_addr  <= offset;
                tbl_wdata <= wdata;
            end
        end
    end

    // Stage two: capture the masked response and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_ack   <= 1'b0;
            io_rdata <= '0;
        end else begin
            io_ack   <= s1_valid;
            io_rdata <= s1_valid ? (rd_src & lane_mask) : '0;
        end
    end

endmodule

// File: rtl/idx_window_bridge.sv
// Module: idx_window_bridge (top)
// Indirect access window: a pointer port and a data port in a small I/O
// space, forwarding data-port accesses to a register bus or a table store.
// Assumes one access in flight; strobes while busy are dropped.
module idx_window_bridge
    import idx_window_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IO_AW  = 3,
    parameter int OFS_W  = 16,
    localparam int BE_W  = DATA_W / 8,
    localparam int PSEL  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BE_W-1:0]   io_be,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              io_ack,
    output logic [DATA_W-1:0] io_rdata,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [OFS_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              tbl_wr,
    output logic [OFS_W-1:0]  tbl_addr,
    output logic [DATA_W-1:0] tbl_wdata
);

    logic              accept;
    logic              busy;
    logic [DATA_W-1:0] ptr_q;
    action_t           act;
    dst_e              dst;

    // Accept a strobe only when no access is in flight.
    always_comb accept = io_req && !busy;
    always_comb dst    = dst_e'(ptr_q[1:0]);

    idx_window_decode #(.BE_W(BE_W)) u_dec (
        .is_wr        (io_wr),
        .is_data_port (io_addr[PSEL]),
        .be           (io_be),
        .dst          (dst),
        .act          (act)
    );

    idx_window_ptr #(.DATA_W(DATA_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && act.ptr_load),
        .wdata (io_wdata),
        .ptr_q (ptr_q)
    );

    idx_window_stage #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .act       (act),
        .be        (io_be),
        .offset    (ptr_q[OFS_W+1:2]),
        .ptr_val   (ptr_q),
        .wdata     (io_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .reg_req   (reg_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .tbl_wr    (tbl_wr),
        .tbl_addr  (tbl_addr),
        .tbl_wdata (tbl_wdata),
        .io_ack    (io_ack),
        .io_rdata  (io_rdata)
    );

endmodule

// File: rtl/idx_window_bridge_chk.sv
// Module: idx_window_bridge_chk
// Temporal checks on the bridge, bound to every instance of the top.
module idx_window_bridge_chk #(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic              io_wr,
    input logic              io_dport,
    input logic [BE_W-1:0]   io_be,
    input logic              io_ack,
    input logic [DATA_W-1:0] io_rdata,
    input logic              reg_req,
    input logic              tbl_wr,
    input logic [DATA_W-1:0] ptr_q
);

    function automatic logic [DATA_W-1:0] lanes(input logic [BE_W-1:0] b);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{b[i]}};
        return m;
    endfunction

    p_ack_two_r12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 io_ack);

    p_bus_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req || tbl_wr) |-> $past(accept));

    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && io_wr && !io_dport && io_be != '1) |=> $stable(ptr_q));

    p_no_side_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && io_wr && io_dport && io_be != '1) |=> (!reg_req && !tbl_wr));

    p_tbl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !io_wr && io_dport && ptr_q[1:0] == 2'b01) |=> ##1 (io_rdata == '0));

    p_lane_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 ((io_rdata & ~lanes($past(io_be, 2))) == '0));

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && tbl_wr));

endmodule

bind idx_window_bridge idx_window_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .io_wr    (io_wr),
    .io_dport (io_addr[2]),
    .io_be    (io_be),
    .io_ack   (io_ack),
    .io_rdata (io_rdata),
    .reg_req  (reg_req),
    .tbl_wr   (tbl_wr),
    .ptr_q    (ptr_q)
);

// File: tb/idx_window_bridge_tb.sv
module idx_window_bridge_tb;

    localparam int DW = 32;
    localparam int AW = 3;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_req = 1'b0;
    logic          io_wr = 1'b0;
    logic [AW-1:0] io_addr = '0;
    logic [3:0]    io_be = '0;
    logic [DW-1:0] io_wdata = '0;
    logic          io_ack;
    logic [DW-1:0] io_rdata;
    logic          reg_req, reg_wr, tbl_wr;
    logic [OW-1:0] reg_addr, tbl_addr;
    logic [DW-1:0] reg_wdata, reg_rdata, tbl_wdata;

    logic [DW-1:0] rf [16];
    logic [DW-1:0] m_rf [16];
    logic [DW-1:0] m_ptr;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    idx_window_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
        .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
        .io_ack(io_ack), .io_rdata(io_rdata), .reg_req(reg_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata)
    );

    // Register-file model on the downstream bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) rf[i] <= 32'hA500_0000 | DW'(i * 32'h0101);
        end else if (reg_req && reg_wr) begin
            rf[reg_addr[3:0]] <= reg_wdata;
        end
    end
    assign reg_rdata = rf[reg_addr[3:0]];

    function automatic logic [DW-1:0] lanes(input logic [3:0] b);
        logic [DW-1:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{b[i]}};
        return m;
    endfunction

    function automatic string tag_of(input logic wr, input logic dp, input logic full,
                                     input logic [1:0] d);
        if (!dp) return wr ? (full ? "R2" : "R3") : "R2";
        if (wr && !full) return "R11";
        if (wr) return (d == 2'b00) ? "R5" : (d == 2'b01) ? "R6" : "R7";
        if (!full) return "R10";
        return (d == 2'b01) ? "R9" : "R8";
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One access through the bridge, checked against the bench model.
    task automatic access(input logic wr, input logic dp, input logic [3:0] be,
                          input logic [DW-1:0] wd);
        logic [1:0]    d = m_ptr[1:0];
        logic          full = (be == 4'hF);
        logic          e_req = dp && (!wr || (full && d == 2'b00));
        logic          e_rwr = dp && wr && full && d == 2'b00;
        logic          e_tbl = dp && wr && full && d == 2'b01;
        logic [OW-1:0] e_ofs = m_ptr[OW+1:2];
        logic [DW-1:0] e_rd;
        string         tg = tag_of(wr, dp, full, d);
        if (!dp) e_rd = m_ptr;
        else if (d == 2'b01) e_rd = '0;
        else e_rd = m_rf[e_ofs[3:0]];
        e_rd = e_rd & lanes(be);
        if (!dp && wr && full) m_ptr = wd;
        if (e_rwr) m_rf[e_ofs[3:0]] = wd;

        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_addr = {dp, 2'b00}; io_be = be; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        chk(io_ack == 1'b0, "R12", "ack early", DW'(io_ack), 0);
        chk(reg_req == e_req && reg_wr == (e_req && e_rwr), tg, "reg_req/reg_wr",
            DW'({reg_req, reg_wr}), DW'({e_req, e_rwr}));
        chk(tbl_wr == e_tbl, tg, "tbl_wr", DW'(tbl_wr), DW'(e_tbl));
        if (e_req) chk(reg_addr == e_ofs, "R4", "reg_addr", DW'(reg_addr), DW'(e_ofs));
        if (e_rwr) chk(reg_wdata == wd, "R5", "reg_wdata", reg_wdata, wd);
        if (e_tbl) chk(tbl_addr == e_ofs && tbl_wdata == wd, "R6", "tbl addr/data",
                       tbl_wdata, wd);
        @(negedge clk);
        chk(io_ack == 1'b1, "R12", "ack", DW'(io_ack), 1);
        if (!wr) chk(io_rdata == e_rd, tg, "rdata", io_rdata, e_rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1DEA5));
        for (int i = 0; i < 16; i++) m_rf[i] = 32'hA500_0000 | DW'(i * 32'h0101);
        m_ptr = '0;
        repeat (3) @(negedge clk);
        chk(io_ack == 0 && reg_req == 0 && tbl_wr == 0, "R1", "idle in reset",
            DW'({io_ack, reg_req, tbl_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(io_ack == 0 && reg_req == 0 && tbl_wr == 0, "R1", "idle after reset",
            DW'({io_ack, reg_req, tbl_wr}), 0);
        access(1'b0, 1'b0, 4'hF, '0);                   // R1 pointer reads zero
        access(1'b1, 1'b0, 4'hF, 32'h0000_000C);        // R2 offset 3, register space
        access(1'b0, 1'b0, 4'hF, '0);                   // R2
        access(1'b1, 1'b0, 4'h3, 32'hFFFF_FFFF);        // R3 narrow load ignored
        access(1'b0, 1'b0, 4'hF, '0);                   // R3 pointer unchanged
        access(1'b1, 1'b1, 4'hF, 32'h1234_5678);        // R5
        access(1'b0, 1'b1, 4'hF, '0);                   // R8
        access(1'b0, 1'b1, 4'h4, '0);                   // R10 one lane
        access(1'b0, 1'b1, 4'hC, '0);                   // R10 upper half
        access(1'b1, 1'b1, 4'h1, 32'hDEAD_BEEF);        // R11
        access(1'b0, 1'b1, 4'hF, '0);                   // R11 location unchanged
        access(1'b1, 1'b0, 4'hF, 32'h0003_FFFD);        // R4 top offset, table
        access(1'b1, 1'b1, 4'hF, 32'hCAFE_F00D);        // R6
        access(1'b0, 1'b1, 4'hF, '0);                   // R9
        access(1'b1, 1'b0, 4'hF, 32'h0000_0016);        // destination 10
        access(1'b1, 1'b1, 4'hF, 32'h0BAD_0BAD);        // R7 dropped
        access(1'b0, 1'b1, 4'hF, '0);                   // R8 reserved reads register
        access(1'b1, 1'b0, 4'hF, 32'h0000_0017);        // destination 11
        access(1'b1, 1'b1, 4'hF, 32'h0BAD_0BAD);        // R7
        for (int n = 0; n < 400; n++) begin
            logic        wr = 1'($urandom);
            logic        dp = ($urandom % 3) != 0;
            logic [3:0]  be = ($urandom % 2) ? 4'hF : 4'($urandom);
            logic [DW-1:0] wd = $urandom;
            if (be == 4'h0) be = 4'h2;
            access(wr, dp, be, wd);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule